// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides, once per oscillator cycle, which parts of a small microcontroller core get a clock. It has four operating states: run, idle, powered-down, and a warm-up state that is used on the way back from power-down. A reduced-rate option is handled separately from these states. Software asks for a mode through single-cycle request strobes. The core also supplies a pulse that marks the last cycle of each instruction. A mode change is applied only on that pulse. As a result, the CPU clock is never cut off partway through an instruction.

In idle, the CPU clock enable drops. The peripheral enable, which feeds the timers, serial and converter logic and the interrupt logic, keeps toggling. The reduced-rate option divides both enables by 32 and can be combined with idle. Power-down needs an arming write followed by a confirming write in the next instruction. It switches off the oscillator and PLL enables and freezes the alternate-function outputs. It also drives the address-latch strobe low, or leaves it undriven when that output is disabled. A wake pin starts a warm-up that waits a software-chosen number of oscillator cycles and then for PLL lock before the clocks come back. An asynchronous reset leaves any state immediately.

The `clk` input models the oscillator. When `osc_en` is low the real oscillator would stop. In this model nothing is clocked in that state except wake-pin sampling.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in run: `cpu_clk_en`=1, `per_clk_en`=1, `osc_en`=1, `pll_en`=1, `div_sel`=0, `alt_hold`=0.
- R2: A `req_idle` strobe takes effect only at the next `eoi` pulse. After that edge `cpu_clk_en`=0, while `per_clk_en` and `osc_en` stay 1.
- R3: Idle is left when `irq`=1, and the block returns to run. `irq` has no effect in run or in power-down.
- R4: `slow_en` is sampled at `eoi`. `div_sel` changes only on the cycle after the last count (31) of a free-running 5-bit divider. With `div_sel`=1, each clock enable is high on exactly one cycle in every 32.
- R5: Reduced rate stacks on idle: `per_clk_en` is high 1 cycle in 32 and `cpu_clk_en` stays 0.
- R6: Power-down is entered only when a `req_pdn` strobe falls in one instruction and another falls in the very next instruction, with entry at the `eoi` that ends the second. A lone strobe has no effect.
- R7: In power-down `osc_en`, `pll_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R8: While `alt_hold`=1 (power-down and warm-up), `alt_pin` holds the `alt_out` value sampled at the entering `eoi` edge. Otherwise `alt_pin` equals `alt_out`.
- R9: While `alt_hold`=1, `ale_out`=0. Otherwise `ale_out` equals `ale_cpu`. `ale_oe` always equals `ale_en`.
- R10: A `wake_pin` pulse in power-down raises `osc_en` and `pll_en` at once. `cpu_clk_en` returns only after `warm_cnt` further cycles have elapsed and `pll_locked`=1.
- R11: If both an idle and a confirming power-down request fall in the same instruction, power-down is entered.
- R12: Asserting `rst_n` low returns the block from power-down to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | PLL lock status |
| eoi | input | 1 | Last cycle of the current instruction |
| req_idle | input | 1 | Idle request strobe |
| req_pdn | input | 1 | Power-down write strobe |
| slow_en | input | 1 | Reduced-rate request level |
| irq | input | 1 | Enabled interrupt pending |
| wake_pin | input | 1 | External wake from power-down |
| warm_cnt | input | 16 | Warm-up length in oscillator cycles |
| alt_out | input | 8 | Alternate-function output values from the core |
| ale_cpu | input | 1 | Address-latch strobe from the core |
| ale_en | input | 1 | Address-latch strobe output enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| div_sel | output | 1 | Divide-by-32 active |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| alt_hold | output | 1 | Alternate-function hold latch enable |
| alt_pin | output | 8 | Alternate-function pin values |
| ale_out | output | 1 | Address-latch strobe pin value |
| ale_oe | output | 1 | Address-latch strobe driver enable |

## Verification
The bench sends lone and consecutive power-down writes, leaves an instruction without a write between two writes, and raises idle and power-down together. A design that counted writes without checking their instruction order would power down by accident, and one with the wrong priority would only idle. It changes `alt_out` after power-down entry and holds PLL lock low past the warm-up count. A design that kept the latches transparent or ignored lock would show a moving pin or an early CPU clock. It counts clock-enable pulses across 64 cycles in reduced rate, both in run and in idle, so a wrong division ratio or a missing peripheral clock in idle shows up as a wrong count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PDN  = 2'd2,
    ST_WARM = 2'd3
  } pm_state_t;
endpackage

// File: rtl/pmc_req.sv
module pmc_req (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic eoi,
  input  logic req_idle,
  input  logic req_pdn,
  input  logic slow_en,
  output logic go_idle,
  output logic go_pdn,
  output logic slow_req
);
  logic arm_cur, arm_cur_n;
  logic armed, armed_n;
  logic idle_cur, idle_cur_n;
  logic slow_n;
  logic pdn_now, idle_now;

  assign pdn_now  = arm_cur | req_pdn;
  assign idle_now = idle_cur | req_idle;
  assign go_pdn   = in_run & eoi & pdn_now & armed;
  assign go_idle  = in_run & eoi & idle_now & ~go_pdn;

  always_comb begin
    arm_cur_n  = arm_cur;
    armed_n    = armed;
    idle_cur_n = idle_cur;
    slow_n     = slow_req;
    if (!in_run) begin
      arm_cur_n  = 1'b0;
      armed_n    = 1'b0;
      idle_cur_n = 1'b0;
    end else if (eoi) begin
      armed_n    = pdn_now & ~go_pdn;
      arm_cur_n  = 1'b0;
      idle_cur_n = 1'b0;
      slow_n     = slow_en;
    end else begin
      arm_cur_n  = pdn_now;
      idle_cur_n = idle_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cur  <= 1'b0;
      armed    <= 1'b0;
      idle_cur <= 1'b0;
      slow_req <= 1'b0;
    end else begin
      arm_cur  <= arm_cur_n;
      armed    <= armed_n;
      idle_cur <= idle_cur_n;
      slow_req <= slow_n;
    end
  end
endmodule

// File: rtl/pmc_clkdiv.sv
module pmc_clkdiv #(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_req,
  output logic tick,
  output logic div_act
);
  localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] cnt, cnt_n;
  logic act_n;

  assign tick = (cnt == LAST);

  always_comb begin
    cnt_n = cnt + 1'b1;
    act_n = tick ? slow_req : div_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_act <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      div_act <= act_n;
    end
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int WARM_W = 16,
  parameter int ALT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_idle,
  input  logic              go_pdn,
  input  logic              irq,
  input  logic              wake_pin,
  input  logic              pll_locked,
  input  logic [WARM_W-1:0] warm_cnt,
  input  logic              tick,
  input  logic              div_act,
  input  logic [ALT_W-1:0]  alt_out,
  input  logic              ale_cpu,
  input  logic              ale_en,
  output pm_state_t         st,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              pll_en,
  output logic              alt_hold,
  output logic [ALT_W-1:0]  alt_pin,
  output logic              ale_out,
  output logic              ale_oe
);
  pm_state_t         st_n;
  logic [WARM_W-1:0] wc, wc_n;
  logic [ALT_W-1:0]  alt_q, alt_q_n;
  logic              pulse, in_run, in_idle;

  always_comb begin
    st_n = st;
    wc_n = wc;
    unique case (st)
      ST_RUN: begin
        if (go_pdn)       st_n = ST_PDN;
        else if (go_idle) st_n = ST_IDLE;
      end
      ST_IDLE: if (irq) st_n = ST_RUN;
      ST_PDN: begin
        wc_n = '0;
        if (wake_pin) st_n = ST_WARM;
      end
      ST_WARM: begin
        if (wc >= warm_cnt) begin
          if (pll_locked) st_n = ST_RUN;
        end else begin
          wc_n = wc + 1'b1;
        end
      end
      default: st_n = ST_RUN;
    endcase
    alt_q_n = go_pdn ? alt_out : alt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      wc    <= '0;
      alt_q <= '0;
    end else begin
      st    <= st_n;
      wc    <= wc_n;
      alt_q <= alt_q_n;
    end
  end

  assign in_run     = (st == ST_RUN);
  assign in_idle    = (st == ST_IDLE);
  assign pulse      = div_act ? tick : 1'b1;
  assign cpu_clk_en = in_run & pulse;
  assign per_clk_en = (in_run | in_idle) & pulse;
  assign osc_en     = (st != ST_PDN);
  assign pll_en     = (st != ST_PDN);
  assign alt_hold   = (st == ST_PDN) | (st == ST_WARM);
  assign alt_pin    = alt_hold ? alt_q : alt_out;
  assign ale_out    = alt_hold ? 1'b0 : ale_cpu;
  assign ale_oe     = ale_en;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_LOG2 = 5,
  parameter int WARM_W   = 16,
  parameter int ALT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_locked,
  input  logic              eoi,
  input  logic              req_idle,
  input  logic              req_pdn,
  input  logic              slow_en,
  input  logic              irq,
  input  logic              wake_pin,
  input  logic [WARM_W-1:0] warm_cnt,
  input  logic [ALT_W-1:0]  alt_out,
  input  logic              ale_cpu,
  input  logic              ale_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              div_sel,
  output logic              osc_en,
  output logic              pll_en,
  output logic              alt_hold,
  output logic [ALT_W-1:0]  alt_pin,
  output logic              ale_out,
  output logic              ale_oe
);
  logic [1:0] rst_sync;
  logic       rst_s;
  logic       go_idle, go_pdn, slow_req, div_tick;
  pm_state_t  st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  pmc_req u_req (
    .clk(clk), .rst_n(rst_s), .in_run(st == ST_RUN), .eoi(eoi),
    .req_idle(req_idle), .req_pdn(req_pdn), .slow_en(slow_en),
    .go_idle(go_idle), .go_pdn(go_pdn), .slow_req(slow_req)
  );

  pmc_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(rst_s), .slow_req(slow_req),
    .tick(div_tick), .div_act(div_sel)
  );

  pmc_fsm #(.WARM_W(WARM_W), .ALT_W(ALT_W)) u_fsm (
    .clk(clk), .rst_n(rst_s), .go_idle(go_idle), .go_pdn(go_pdn),
    .irq(irq), .wake_pin(wake_pin), .pll_locked(pll_locked),
    .warm_cnt(warm_cnt), .tick(div_tick), .div_act(div_sel),
    .alt_out(alt_out), .ale_cpu(ale_cpu), .ale_en(ale_en), .st(st),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .pll_en(pll_en), .alt_hold(alt_hold), .alt_pin(alt_pin),
    .ale_out(ale_out), .ale_oe(ale_oe)
  );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
  import pmc_pkg::*;
#(
  parameter int ALT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoi,
  input logic             div_tick,
  input pm_state_t        st,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             div_sel,
  input logic             osc_en,
  input logic             pll_en,
  input logic             alt_hold,
  input logic [ALT_W-1:0] alt_pin,
  input logic             ale_out
);
  // R2
  mode_at_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_RUN && st != ST_RUN) |-> $past(eoi));

  // R4
  div_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel != $past(div_sel)) |-> $past(div_tick));

  // R7
  pdn_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en && !pll_en));

  // R2
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  // R8
  alt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_hold && $past(alt_hold)) |-> $stable(alt_pin));

  // R9
  ale_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_hold |-> !ale_out);

  // R10
  no_direct_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_PDN) |-> (st != ST_RUN));
endmodule

bind pwr_mode_ctrl pmc_chk #(.ALT_W(ALT_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .eoi(eoi), .div_tick(div_tick), .st(st),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .div_sel(div_sel),
  .osc_en(osc_en), .pll_en(pll_en), .alt_hold(alt_hold),
  .alt_pin(alt_pin), .ale_out(ale_out)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, pll_locked, eoi, req_idle, req_pdn, slow_en, irq, wake_pin;
  logic [15:0] warm_cnt;
  logic [7:0]  alt_out, alt_pin;
  logic        ale_cpu, ale_en;
  logic        cpu_clk_en, per_clk_en, div_sel, osc_en, pll_en, alt_hold, ale_out, ale_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .eoi(eoi),
    .req_idle(req_idle), .req_pdn(req_pdn), .slow_en(slow_en), .irq(irq),
    .wake_pin(wake_pin), .warm_cnt(warm_cnt), .alt_out(alt_out),
    .ale_cpu(ale_cpu), .ale_en(ale_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .div_sel(div_sel), .osc_en(osc_en),
    .pll_en(pll_en), .alt_hold(alt_hold), .alt_pin(alt_pin),
    .ale_out(ale_out), .ale_oe(ale_oe)
  );

  // {alt_out[7:0], ale_cpu, ale_en}
  localparam logic [9:0] VEC [8] = '{
    10'b0000_0000_0_0, 10'b1111_1111_1_1, 10'b1010_0101_1_0, 10'b0101_1010_0_1,
    10'b1000_0001_1_1, 10'b0111_1110_0_0, 10'b0011_1100_1_1, 10'b1100_0011_0_1
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; cyc(1); eoi = 1'b0;
  endtask

  task automatic write_pdn();
    req_pdn = 1'b1; cyc(1); req_pdn = 1'b0; cyc(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
  endtask

  task automatic count_pulses(input int n, output int c_cpu, output int c_per);
    c_cpu = 0; c_per = 0;
    for (int i = 0; i < n; i++) begin
      c_cpu += int'(cpu_clk_en);
      c_per += int'(per_clk_en);
      cyc(1);
    end
  endtask

  task automatic enter_pdn(input logic [7:0] v);
    write_pdn(); pulse_eoi(); cyc(1);
    req_pdn = 1'b1; alt_out = v; eoi = 1'b1; cyc(1);
    req_pdn = 1'b0; eoi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cc, cp;
    rst_n = 1'b0; pll_locked = 1'b1; eoi = 1'b0; req_idle = 1'b0; req_pdn = 1'b0;
    slow_en = 1'b0; irq = 1'b0; wake_pin = 1'b0; warm_cnt = 16'd10;
    alt_out = 8'h00; ale_cpu = 1'b1; ale_en = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(4);

    // R1 reset state
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 per_clk_en", per_clk_en, 1);
    check("R1 osc_en", osc_en, 1);
    check("R1 pll_en", pll_en, 1);
    check("R1 div_sel", div_sel, 0);
    check("R1 alt_hold", alt_hold, 0);

    // R8 R9 pass-through table in run
    for (int i = 0; i < 8; i++) begin
      {alt_out, ale_cpu, ale_en} = VEC[i];
      cyc(1);
      check("R8 alt_pin pass", alt_pin, VEC[i][9:2]);
      check("R9 ale_out pass", ale_out, VEC[i][1]);
      check("R9 ale_oe", ale_oe, VEC[i][0]);
    end
    ale_cpu = 1'b1; ale_en = 1'b1;

    // R3 irq in run has no effect
    irq = 1'b1; cyc(3); irq = 1'b0;
    check("R3 irq in run", cpu_clk_en, 1);

    // R2 idle waits for eoi
    req_idle = 1'b1; cyc(1); req_idle = 1'b0; cyc(3);
    check("R2 no eoi yet", cpu_clk_en, 1);
    pulse_eoi();
    check("R2 idle cpu", cpu_clk_en, 0);
    check("R2 idle per", per_clk_en, 1);
    check("R2 idle osc", osc_en, 1);
    // R3 exit idle
    irq = 1'b1; cyc(1); irq = 1'b0;
    check("R3 idle exit", cpu_clk_en, 1);

    // R4 reduced rate
    slow_en = 1'b1; cyc(2);
    check("R4 not before eoi", div_sel, 0);
    pulse_eoi(); cyc(40);
    check("R4 div_sel", div_sel, 1);
    count_pulses(64, cc, cp);
    check("R4 cpu 1 in 32", cc, 2);
    check("R4 per 1 in 32", cp, 2);
    // R5 slow stacked on idle
    req_idle = 1'b1; eoi = 1'b1; cyc(1); req_idle = 1'b0; eoi = 1'b0;
    count_pulses(64, cc, cp);
    check("R5 cpu in idle", cc, 0);
    check("R5 per in idle", cp, 2);
    irq = 1'b1; cyc(1); irq = 1'b0;
    slow_en = 1'b0; pulse_eoi(); cyc(40);
    check("R4 back to full rate", div_sel, 0);

    // R6 lone writes ignored
    write_pdn(); pulse_eoi(); pulse_eoi();
    check("R6 lone write osc", osc_en, 1);
    write_pdn(); pulse_eoi(); cyc(2); pulse_eoi();
    check("R6 gap osc", osc_en, 1);
    write_pdn(); write_pdn(); pulse_eoi(); pulse_eoi();
    check("R6 double write same instr", osc_en, 1);

    // R6 R7 R8 R9 proper entry
    ale_cpu = 1'b1;
    enter_pdn(8'hA5);
    check("R6 entry osc", osc_en, 0);
    check("R7 pll off", pll_en, 0);
    check("R7 cpu off", cpu_clk_en, 0);
    check("R7 per off", per_clk_en, 0);
    alt_out = 8'h3C; cyc(2);
    check("R8 alt hold", alt_hold, 1);
    check("R8 alt frozen", alt_pin, 8'hA5);
    check("R9 ale low", ale_out, 0);
    check("R9 ale_oe", ale_oe, 1);
    ale_en = 1'b0; cyc(1);
    check("R9 ale undriven", ale_oe, 0);
    ale_en = 1'b1;
    // R3 irq ignored in power-down
    irq = 1'b1; cyc(3); irq = 1'b0;
    check("R3 irq in pdn", osc_en, 0);

    // R10 wake with lock low
    pll_locked = 1'b0; warm_cnt = 16'd10;
    wake_pin = 1'b1; cyc(1); wake_pin = 1'b0;
    check("R10 osc on", osc_en, 1);
    check("R10 pll on", pll_en, 1);
    cyc(20);
    check("R10 wait lock", cpu_clk_en, 0);
    check("R8 hold in warm", alt_pin, 8'hA5);
    pll_locked = 1'b1; cyc(2);
    check("R10 resumed", cpu_clk_en, 1);
    check("R8 released", alt_pin, 8'h3C);

    // R10 count respected with lock high
    enter_pdn(8'h11);
    wake_pin = 1'b1; cyc(1); wake_pin = 1'b0;
    cyc(9);
    check("R10 count not done", cpu_clk_en, 0);
    cyc(2);
    check("R10 count done", cpu_clk_en, 1);

    // R11 priority
    write_pdn(); pulse_eoi(); cyc(1);
    req_pdn = 1'b1; req_idle = 1'b1; cyc(1); req_pdn = 1'b0; req_idle = 1'b0;
    pulse_eoi();
    check("R11 pdn wins", osc_en, 0);

    // R12 reset leaves power-down
    do_reset();
    check("R12 osc", osc_en, 1);
    check("R12 cpu", cpu_clk_en, 1);
    check("R12 hold", alt_hold, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule